// File: doc/BRIEF.md
# Late-Write Registered Synchronous SRAM

This block is a single-clock static RAM. Commands are registered and read data is registered. Chip select, the write command, the address and the per-lane write enables are all sampled on the rising clock edge. A write takes its data on the edge that follows its command edge. The data word is made of 9-bit lanes, and each lane has its own active-low write enable. Read data comes back from an output register two edges after the read command. A drive-enable output, gated without a clock by an active-low output enable, stands in for a three-state data bus.

A write becomes pending once its data has been sampled. It is committed to the array one edge later, so the array's write port is driven only from flops. A read that arrives before the commit gets the pending data, merged lane by lane over the stored word. The array cannot enforce the one dead cycle that a read-to-write turnaround needs on a shared bus. A write command that directly follows a read command therefore raises a one-cycle violation flag. A sleep input makes the block ignore new commands.

Top module: `lw_sram`

## Requirements
- R1: A command is accepted on a rising edge only when `sel_n`=0 and `sleep`=0 at that edge. `wr_n`=0 makes it a write and `wr_n`=1 makes it a read. With `sel_n`=1 the memory, `rdata` and `rdata_oe` are unaffected.
- R2: For a read accepted at edge k, `rdata` takes the addressed word at edge k+1. `rdata_oe` is high from edge k+1 to edge k+2 while `oe_n`=0.
- R3: The data of a write accepted at edge k is the `wdata` value sampled at edge k+1. `wdata` sampled at any other edge has no effect on memory.
- R4: Lane i of a word is bits [9i+8:9i]. A write updates lane i only if `lane_we_n[i]`=0 at its command edge, and the other lanes keep their previous contents.
- R5: A write accepted at the edge directly after an accepted read sets `turn_err` high for exactly the cycle after that edge. The write is still performed. With at least one non-accepted edge in between, `turn_err` stays low.
- R6: `oe_n`=1 forces `rdata_oe` low at once, without waiting for a clock edge. Returning `oe_n` to 0 restores it within the same cycle.
- R7: `rdata_oe` is never high except in the cycle that holds a read result. `rdata` changes only at edges that load a read result.
- R8: A command presented with `sleep`=1 is ignored: no memory change, no read output, no `turn_err`. A write accepted before sleep rose still takes its data on the next edge and completes.
- R9: A read issued directly after a write to the same address returns the new data in the enabled lanes and the old data in the masked lanes.
- R10: `rst_n`=0 clears `rdata`, `rdata_oe` and `turn_err` at once without a clock, and cancels commands in flight. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Synchronous chip select, active low |
| wr_n | input | 1 | Synchronous write command, active low (high = read) |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address |
| wdata | input | LANES*9 | Write data, sampled one edge after its command |
| sleep | input | 1 | Sleep, active high; blocks new commands |
| oe_n | input | 1 | Output enable, active low, not clocked |
| rdata | output | LANES*9 | Registered read data |
| rdata_oe | output | 1 | Data bus drive enable (low = high impedance) |
| turn_err | output | 1 | Read-to-write turnaround violation pulse |

## Verification
The assertions take several things for granted about the inputs. The control inputs must be settled around each rising edge, and the pipeline can only be judged once two edges have passed since reset, so the checker counts edges from reset before it relates outputs to past commands. The bench drives every input one nanosecond after a rising edge and toggles `oe_n` in mid-cycle only when it probes the unclocked path. Reset is pulsed only after two idle cycles, so no write is ever caught between data capture and commit. Stimulus reads only addresses that were first written with all lanes enabled. It also produces back-to-back read-then-write pairs on purpose, so the turnaround properties are triggered as well as left idle.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
   // Decoded command class held in the input register stage
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/lw_sram_cmd.sv
// Input register stage: command decode, address and lane-mask capture,
// read-to-write turnaround detection.
module lw_sram_cmd
   import lw_sram_pkg::*;
#(
   parameter int LANES = 2,
   parameter int AW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n,
   input  logic             wr_n,
   input  logic             sleep,
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] lane_we_n,
   output op_e              op_q,
   output logic [AW-1:0]    addr_q,
   output logic [LANES-1:0] mask_q,
   output logic             turn_err
);
   op_e op_d;

   always_comb begin
      if (sel_n || sleep) op_d = OP_NONE;
      else if (!wr_n)     op_d = OP_WRITE;
      else                op_d = OP_READ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q     <= OP_NONE;
         addr_q   <= '0;
         mask_q   <= '0;
         turn_err <= 1'b0;
      end else begin
         op_q     <= op_d;
         turn_err <= (op_d == OP_WRITE) && (op_q == OP_READ);
         if (op_d != OP_NONE) begin
            addr_q <= addr;
            mask_q <= ~lane_we_n;
         end
      end
   end
endmodule

// File: rtl/lw_sram_wstage.sv
// Late-write data stage: samples write data one edge after the command
// and holds it as the pending write until the array commit.
module lw_sram_wstage
   import lw_sram_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   parameter int AW     = 8,
   parameter int W      = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  op_e              op_q,
   input  logic [AW-1:0]    addr_q,
   input  logic [LANES-1:0] mask_q,
   input  logic [W-1:0]     wdata,
   output logic             pend_vld,
   output logic [AW-1:0]    pend_addr,
   output logic [LANES-1:0] pend_mask,
   output logic [W-1:0]     pend_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_addr <= '0;
         pend_mask <= '0;
         pend_data <= '0;
      end else begin
         pend_vld <= (op_q == OP_WRITE);
         if (op_q == OP_WRITE) begin
            pend_addr <= addr_q;
            pend_mask <= mask_q;
            pend_data <= wdata;
         end
      end
   end
endmodule

// File: rtl/lw_sram_array.sv
// Storage: one inferred memory per lane, lane-masked write, unregistered read.
module lw_sram_array #(
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 256,
   parameter int AW     = $clog2(DEPTH),
   parameter int W      = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [LANES-1:0] wmask,
   input  logic [W-1:0]     wdata,
   input  logic [AW-1:0]    raddr,
   output logic [W-1:0]     rdata
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wmask[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
      end

      assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
   end
endmodule

// File: rtl/lw_sram_rstage.sv
// Output register stage: per-lane bypass of the pending write, read
// data register and the unclocked drive-enable gate.
module lw_sram_rstage
   import lw_sram_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   parameter int AW     = 8,
   parameter int W      = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  op_e              op_q,
   input  logic [AW-1:0]    addr_q,
   input  logic [W-1:0]     mem_rdata,
   input  logic             pend_vld,
   input  logic [AW-1:0]    pend_addr,
   input  logic [LANES-1:0] pend_mask,
   input  logic [W-1:0]     pend_data,
   input  logic             oe_n,
   output logic [W-1:0]     rdata,
   output logic             rdata_oe
);
   logic         hit;
   logic [W-1:0] merged;
   logic         rd_vld;

   assign hit = pend_vld && (pend_addr == addr_q);

   for (genvar l = 0; l < LANES; l++) begin : g_merge
      assign merged[l*LANE_W +: LANE_W] = (hit && pend_mask[l])
                                        ? pend_data[l*LANE_W +: LANE_W]
                                        : mem_rdata[l*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld <= 1'b0;
         rdata  <= '0;
      end else begin
         rd_vld <= (op_q == OP_READ);
         if (op_q == OP_READ) rdata <= merged;
      end
   end

   assign rdata_oe = rd_vld && !oe_n;
endmodule

// File: rtl/lw_sram.sv
// Late-write registered synchronous SRAM, top level.
module lw_sram
   import lw_sram_pkg::*;
#(
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 256,
   parameter int AW     = $clog2(DEPTH),
   parameter int W      = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_n,
   input  logic             wr_n,
   input  logic [LANES-1:0] lane_we_n,
   input  logic [AW-1:0]    addr,
   input  logic [W-1:0]     wdata,
   input  logic             sleep,
   input  logic             oe_n,
   output logic [W-1:0]     rdata,
   output logic             rdata_oe,
   output logic             turn_err
);
   // Elaboration-time parameter checks
   if (LANES < 1 || LANES > 8) begin : g_bad_lanes
      $error("lw_sram: LANES must be 1..8");
   end
   if (LANE_W != 9) begin : g_bad_lane_w
      $error("lw_sram: lanes are 9 bits wide");
   end
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("lw_sram: DEPTH must be a power of two, at least 2");
   end
   if (W != LANES * LANE_W) begin : g_bad_w
      $error("lw_sram: W must equal LANES*LANE_W");
   end

   op_e              op_q;
   logic [AW-1:0]    addr_q;
   logic [LANES-1:0] mask_q;
   logic             pend_vld;
   logic [AW-1:0]    pend_addr;
   logic [LANES-1:0] pend_mask;
   logic [W-1:0]     pend_data;
   logic [W-1:0]     mem_rdata;

   lw_sram_cmd #(.LANES(LANES), .AW(AW)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_n     (sel_n),
      .wr_n      (wr_n),
      .sleep     (sleep),
      .addr      (addr),
      .lane_we_n (lane_we_n),
      .op_q      (op_q),
      .addr_q    (addr_q),
      .mask_q    (mask_q),
      .turn_err  (turn_err)
   );

   lw_sram_wstage #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW), .W(W)) u_wstage (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_q      (op_q),
      .addr_q    (addr_q),
      .mask_q    (mask_q),
      .wdata     (wdata),
      .pend_vld  (pend_vld),
      .pend_addr (pend_addr),
      .pend_mask (pend_mask),
      .pend_data (pend_data)
   );

   lw_sram_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH), .AW(AW), .W(W)) u_array (
      .clk   (clk),
      .we    (pend_vld),
      .waddr (pend_addr),
      .wmask (pend_mask),
      .wdata (pend_data),
      .raddr (addr_q),
      .rdata (mem_rdata)
   );

   lw_sram_rstage #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW), .W(W)) u_rstage (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_q      (op_q),
      .addr_q    (addr_q),
      .mem_rdata (mem_rdata),
      .pend_vld  (pend_vld),
      .pend_addr (pend_addr),
      .pend_mask (pend_mask),
      .pend_data (pend_data),
      .oe_n      (oe_n),
      .rdata     (rdata),
      .rdata_oe  (rdata_oe)
   );
endmodule

// File: rtl/lw_sram_chk.sv
// Port-level property checker, bound into every lw_sram instance.
module lw_sram_chk #(
   parameter int W = 18
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sel_n,
   input logic         wr_n,
   input logic         sleep,
   input logic         oe_n,
   input logic [W-1:0] rdata,
   input logic         rdata_oe,
   input logic         turn_err
);
   logic [1:0] edges;
   logic       rd_cmd;
   logic       wr_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              edges <= 2'd0;
      else if (edges != 2'd3)  edges <= edges + 2'd1;
   end

   assign rd_cmd = !sel_n && !sleep &&  wr_n;
   assign wr_cmd = !sel_n && !sleep && !wr_n;

   AST_OE_FORCES_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rdata_oe); // R6

   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (edges >= 2'd2) && $past(rd_cmd, 2) && !oe_n |-> rdata_oe); // R2

   AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (edges >= 2'd2) && rdata_oe |-> $past(rd_cmd, 2)); // R7

   AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (edges >= 2'd2) && !$past(rd_cmd, 2) |-> $stable(rdata)); // R7

   AST_TURN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (edges >= 2'd1) && wr_cmd && $past(rd_cmd) |=> turn_err); // R5

   AST_TURN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (edges >= 2'd2) && turn_err |-> $past(wr_cmd) && $past(rd_cmd, 2)); // R5

   AST_SLEEP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (edges >= 2'd2) && $past(sleep, 2) |-> !rdata_oe); // R8

   AST_DESELECT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (edges >= 2'd1) && $past(sel_n) |-> !turn_err); // R1
endmodule

bind lw_sram lw_sram_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_n    (sel_n),
   .wr_n     (wr_n),
   .sleep    (sleep),
   .oe_n     (oe_n),
   .rdata    (rdata),
   .rdata_oe (rdata_oe),
   .turn_err (turn_err)
);

// File: tb/lw_sram_tb.sv
`timescale 1ns/1ps
module lw_sram_tb;
   localparam int LANES  = 2;
   localparam int LANE_W = 9;
   localparam int DEPTH  = 256;
   localparam int AW     = $clog2(DEPTH);
   localparam int W      = LANES * LANE_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sel_n = 1'b1;
   logic             wr_n = 1'b1;
   logic [LANES-1:0] lane_we_n = '1;
   logic [AW-1:0]    addr = '0;
   logic [W-1:0]     wdata = '0;
   logic             sleep = 1'b0;
   logic             oe_n = 1'b0;
   logic [W-1:0]     rdata;
   logic             rdata_oe;
   logic             turn_err;

   always #2.5 clk = ~clk;   // 200 MHz

   lw_sram #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .lane_we_n(lane_we_n),
      .addr(addr), .wdata(wdata), .sleep(sleep), .oe_n(oe_n),
      .rdata(rdata), .rdata_oe(rdata_oe), .turn_err(turn_err)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 1'b0;
   bit    running = 1'b0;
   string cur_req = "R1";

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [W-1:0]     ref_mem [DEPTH];
   int               m_prev_op = 0;       // 0 none, 1 read, 2 write
   int               m_prev_addr = 0;
   int               m_waddr = 0;
   logic [LANES-1:0] m_wmask = '0;
   bit               m_wpend = 1'b0;
   bit               m_rd_vld = 1'b0;
   bit               m_err = 1'b0;
   logic [W-1:0]     m_rdata = '0;
   int               wq[$];                // addresses of writes awaiting data

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_prev_op = 0; m_wpend = 1'b0; m_rd_vld = 1'b0; m_err = 1'b0;
         m_rdata = '0; wq.delete();
      end else begin
         int op;
         if (m_wpend) begin
            void'(wq.pop_front());
            for (int l = 0; l < LANES; l++)
               if (m_wmask[l]) ref_mem[m_waddr][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
         end
         m_rd_vld = (m_prev_op == 1);
         if (m_prev_op == 1) m_rdata = ref_mem[m_prev_addr];
         op = (sel_n || sleep) ? 0 : (wr_n ? 1 : 2);
         m_err   = (op == 2) && (m_prev_op == 1);
         m_wpend = (op == 2);
         if (op == 2) begin
            m_waddr = int'(addr);
            m_wmask = ~lane_we_n;
            wq.push_back(int'(addr));
         end
         m_prev_op   = op;
         m_prev_addr = int'(addr);
      end
   end

   // Compare on every cycle at the falling edge
   always @(negedge clk) begin
      if (rst_n && running) begin
         check(rdata_oe === (m_rd_vld && !oe_n), cur_req, "R2/R6 drive enable",
               W'(rdata_oe), W'(m_rd_vld && !oe_n));
         check(turn_err === m_err, cur_req, "R5 turnaround flag", W'(turn_err), W'(m_err));
         check(rdata === m_rdata, cur_req, "R7 read data", rdata, m_rdata);
      end
   end

   // ---------------- stimulus ----------------
   logic [W-1:0] next_d = '0;

   task automatic drive(input bit s_n, input bit w_n, input int a,
                        input logic [LANES-1:0] be_n, input logic [W-1:0] d,
                        input bit sl = 1'b0);
      @(posedge clk); #1;
      sel_n = s_n; wr_n = w_n; addr = a[AW-1:0]; lane_we_n = be_n; sleep = sl;
      wdata  = next_d;   // data belonging to the previous edge's command
      next_d = d;
   endtask

   task automatic wr(input int a, input logic [LANES-1:0] be_n, input logic [W-1:0] d);
      drive(1'b0, 1'b0, a, be_n, d);
   endtask
   task automatic rd(input int a);
      drive(1'b0, 1'b1, a, '1, W'($urandom));
   endtask
   task automatic idle();
      drive(1'b1, 1'b1, int'($urandom % DEPTH), '1, W'($urandom));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // Reset state, R10
      repeat (3) @(posedge clk);
      #1;
      check(rdata_oe === 1'b0, "R10", "oe in reset", W'(rdata_oe), '0);
      check(turn_err === 1'b0, "R10", "err in reset", W'(turn_err), '0);
      check(rdata === '0, "R10", "rdata in reset", rdata, '0);
      rst_n = 1'b1;
      running = 1'b1;

      // Preload with full-lane writes, back to back, R1 and R3
      cur_req = "R3";
      for (int i = 0; i < 16; i++) wr(i, '0, W'($urandom));
      idle();
      cur_req = "R1";
      for (int i = 0; i < 16; i++) rd(i);
      idle(); idle();

      // Lane masking, R4
      cur_req = "R4";
      wr(3, 2'b10, 18'h3_0155);   // lane 0 only
      idle();
      wr(4, 2'b01, 18'h2_AA00);   // lane 1 only
      idle();
      rd(3); rd(4); idle(); idle();

      // Bypass of pending write, R9
      cur_req = "R9";
      wr(5, '0, 18'h1_2345); rd(5);
      wr(6, 2'b01, 18'h3_FE00); rd(6);
      wr(7, 2'b10, 18'h0_01AB); wr(7, 2'b01, 18'h1_5400); rd(7);
      idle(); idle();

      // Turnaround flag, R5
      cur_req = "R5";
      rd(8); wr(9, '0, 18'h0_BEEF);
      idle();
      rd(8); idle(); wr(10, '0, 18'h2_1111);
      idle(); rd(9); rd(10); idle(); idle();

      // Deselected write is ignored, R1
      cur_req = "R1";
      drive(1'b1, 1'b0, 11, '0, 18'h3_FFFF);
      idle(); rd(11); idle(); idle();

      // Sleep blocks commands; in-flight write completes, R8
      cur_req = "R8";
      drive(1'b0, 1'b0, 12, '0, 18'h0_0F0F, 1'b1);
      drive(1'b0, 1'b1, 12, '1, 18'h0, 1'b1);
      wr(13, '0, 18'h1_C3C3);
      drive(1'b0, 1'b1, 13, '1, 18'h0, 1'b1);
      idle(); rd(12); rd(13); idle(); idle();

      // Unclocked output enable, R6
      cur_req = "R6";
      rd(14); idle(); idle();
      #0.5 oe_n = 1'b1;
      #0.2 check(rdata_oe === 1'b0, "R6", "oe_n high mid-cycle", W'(rdata_oe), '0);
      oe_n = 1'b0;
      #0.2 check(rdata_oe === 1'b1, "R6", "oe_n low mid-cycle", W'(rdata_oe), W'(1));
      idle(); idle();

      // Reset mid-run keeps contents, R10
      cur_req = "R10";
      idle(); idle();
      @(posedge clk); #1 rst_n = 1'b0;
      #0.2 check(rdata === '0, "R10", "rdata cleared", rdata, '0);
      check(rdata_oe === 1'b0, "R10", "oe cleared", W'(rdata_oe), '0);
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      rd(5); idle(); idle();

      // Random traffic on preloaded addresses, R7 and all others
      cur_req = "R7";
      for (int i = 0; i < 400; i++) begin
         int r = int'($urandom % 10);
         oe_n = ($urandom % 8) == 0;
         if (r < 4)       wr(int'($urandom % 16), LANES'($urandom), W'($urandom));
         else if (r < 8)  rd(int'($urandom % 16));
         else if (r == 8) drive(1'b0, 1'($urandom), int'($urandom % 16), '0, W'($urandom), 1'b1);
         else             idle();
      end
      oe_n = 1'b0;
      idle(); idle(); idle();
      @(negedge clk);
      running = 1'b0;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule